// File: doc/BRIEF.md
# Page Access Guard with Fault Recording

This block sits behind a page-table walker. For each translated access it receives the final leaf entry, the memory location that entry came from, the kind of access (load, store, instruction fetch, or a combined store-and-fetch) and the privilege level. It decides whether the access may proceed and which read, write and execute rights may be cached for the page. When an allowed access must set the entry's referenced or modified flag, it produces a write-back of the updated entry to the same location. A bit in the entry's permission field, together with the access kind, selects either success, a protection error or a privilege violation.

Rejected accesses are logged in two software-visible registers: a status word and the page-aligned faulting address. Reading the status word clears it. If a second fault arrives before software has read the first, the status word keeps a sticky overwrite marker. A no-fault mode input lets user-mode errors pass silently. A single one-cycle fault pulse goes to the processor when traps are enabled and no-fault mode is off. Every response is registered, so outputs appear one clock after the request.

Top module: `mmu_access_guard`

## Requirements
- R1: The access index is the 3-bit value {is_store, is_fetch, is_supervisor}, with the store flag at bit 2 and the supervisor flag at bit 0. It appears in bits [7:5] of the fault status word.
- R2: The entry's permission field sits at bits [4:2]. Rights for codes 0..4 are R, RW, RX, RWX and X for both privileges. For codes 5/6/7, user rights are R, none, none and supervisor rights are RW, RX, RWX. A user access to code 6 or 7 yields result 12 (privilege). Otherwise an access whose needs are not covered gives 8 (protection). A load needs R, a fetch needs X and a store needs W; store+fetch needs both. Anything else gives 0. `rsp_code` carries this result one cycle after `req_valid`.
- R3: When `nf_mode` is 1 and the access is from user mode, a nonzero result is treated as allowed: `rsp_allow` is 1, nothing is recorded, and no fault pulse is sent. Supervisor faults are not affected.
- R4: On an allowed access the updated entry has the referenced flag (bit 5) set. On a store it also has the modified flag (bit 6) set. `wb_valid` pulses, with `wb_ptr` equal to the entry's location and `wb_data` equal to the updated entry, only when one of these flags changes.
- R5: Write right is granted only if the modified flag is set after the update, that is, already set or being set by this store.
- R6: `rsp_rights` is {R, W, X} from the R2 table for an allowed access, masked per R5, and 0 for a rejected one.
- R7: On a recorded fault the status word becomes (idx<<5) | code | 2, ORed with 1 if it was nonzero beforehand.
- R8: A recorded fault loads the address register with the request address with its low PAGE_BITS bits cleared.
- R9: A read with `reg_sel`=0 returns the status word on `reg_rdata` one cycle later and clears it. With `reg_sel`=1 the read returns the address register and leaves it unchanged. If a fault is recorded in the same cycle as a status read, the read returns the old value and the new status carries no overwrite mark.
- R10: `fault` is a one-cycle pulse, aligned with `rsp_valid`, for a recorded fault while `traps_en` is 1 and `nf_mode` is 0.
- R11: After reset, all response outputs are 0 and both registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | VA_W | Virtual address of the access |
| req_pte | input | PTE_W | Leaf entry from the walker |
| req_pte_ptr | input | PA_W | Location the entry was read from |
| req_store | input | 1 | Access writes |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Access is from supervisor mode |
| nf_mode | input | 1 | No-fault mode |
| traps_en | input | 1 | Traps enabled |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0: status word, 1: fault address |
| rsp_valid | output | 1 | Response strobe |
| rsp_allow | output | 1 | Access may proceed |
| rsp_code | output | 4 | Result code 0, 8 or 12 |
| rsp_rights | output | 3 | Granted {R, W, X} |
| wb_valid | output | 1 | Entry write-back strobe |
| wb_ptr | output | PA_W | Write-back location |
| wb_data | output | PTE_W | Updated entry |
| fault | output | 1 | Trap pulse to the processor |
| reg_rdata | output | VA_W | Register read data |

## Verification
The hardest states to reach from the ports are the status overwrite marker and a fault recorded in the same cycle as a status read, because the bench normally clears the status after every vector. The stimulus reaches the first by sending two rejected accesses back to back with no read between them. It reaches the second by raising a status read in the same cycle as a rejected request and then reading again. The main sweep covers every combination of access index, permission code, both entry flags, no-fault mode and trap enable.

// File: rtl/mmu_guard_pkg.sv
package mmu_guard_pkg;
  localparam int IDX_W  = 3;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_OK   = 4'd0;
  localparam logic [CODE_W-1:0] CODE_PROT = 4'd8;
  localparam logic [CODE_W-1:0] CODE_PRIV = 4'd12;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  function automatic logic [IDX_W-1:0] make_index(logic st, logic fe, logic sup);
    return {st, fe, sup};
  endfunction

  function automatic rights_t base_rights(logic user, logic [2:0] perm);
    rights_t r;
    case (perm)
      3'd0:    r = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
      3'd1:    r = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
      3'd2:    r = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
      3'd3:    r = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
      3'd4:    r = '{rd: 1'b0, wr: 1'b0, ex: 1'b1};
      3'd5:    r = '{rd: 1'b1, wr: !user, ex: 1'b0};
      3'd6:    r = '{rd: !user, wr: 1'b0, ex: !user};
      default: r = '{rd: !user, wr: !user, ex: !user};
    endcase
    return r;
  endfunction

  function automatic logic [CODE_W-1:0] check_code(logic [IDX_W-1:0] idx, logic [2:0] perm);
    rights_t have;
    logic    user;
    logic    miss;
    user = !idx[0];
    have = base_rights(user, perm);
    miss = (idx[2] && !have.wr) || (idx[1] && !have.ex) ||
           (!idx[2] && !idx[1] && !have.rd);
    if (user && perm[2] && perm[1]) return CODE_PRIV;
    if (miss) return CODE_PROT;
    return CODE_OK;
  endfunction
endpackage

// File: rtl/mmu_perm_lookup.sv
module mmu_perm_lookup
  import mmu_guard_pkg::*;
(
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [2:0]        perm,
  input  logic              mod_after,
  output logic [CODE_W-1:0] code,
  output rights_t           granted
);
  rights_t base_r;

  assign base_r = base_rights(!acc_idx[0], perm);
  assign code   = check_code(acc_idx, perm);

  always_comb begin
    granted    = base_r;
    granted.wr = base_r.wr & mod_after;
  end
endmodule

// File: rtl/mmu_ref_update.sv
module mmu_ref_update #(
  parameter int PTE_W   = 32,
  parameter int REF_BIT = 5,
  parameter int MOD_BIT = 6
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             is_store,
  input  logic             allow,
  output logic [PTE_W-1:0] pte_new,
  output logic             wb_need
);
  logic set_ref;
  logic set_mod;

  assign set_ref = !pte[REF_BIT];
  assign set_mod = is_store && !pte[MOD_BIT];

  always_comb begin
    pte_new          = pte;
    pte_new[REF_BIT] = 1'b1;
    if (is_store) pte_new[MOD_BIT] = 1'b1;
  end

  assign wb_need = allow && (set_ref || set_mod);
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
  import mmu_guard_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int STAT_W    = 8,
  localparam int PG_W     = VA_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_fault,
  input  logic [IDX_W-1:0]  rec_idx,
  input  logic [CODE_W-1:0] rec_code,
  input  logic [PG_W-1:0]   rec_page,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [VA_W-1:0]   rdata,
  output logic [STAT_W-1:0] stat_q
);
  logic [VA_W-1:0]   far_q;
  logic              rd_clr;
  logic [STAT_W-1:0] fresh;
  logic              ovw;

  assign rd_clr = rd_en && !rd_sel;
  assign fresh  = STAT_W'({rec_idx, 1'b0, rec_code}) | STAT_W'(2);
  assign ovw    = (stat_q != '0) && !rd_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      far_q  <= '0;
      rdata  <= '0;
    end else begin
      if (rec_fault) begin
        stat_q <= fresh | STAT_W'(ovw);
        far_q  <= {rec_page, {PAGE_BITS{1'b0}}};
      end else if (rd_clr) begin
        stat_q <= '0;
      end
      if (rd_en) begin
        rdata <= rd_sel ? far_q : {{(VA_W-STAT_W){1'b0}}, stat_q};
      end
    end
  end
endmodule

// File: rtl/mmu_access_guard.sv
module mmu_access_guard
  import mmu_guard_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 36,
  parameter int PTE_W     = 32,
  parameter int PAGE_BITS = 12,
  parameter int PERM_LSB  = 2,
  parameter int REF_BIT   = 5,
  parameter int MOD_BIT   = 6,
  localparam int STAT_W   = 8,
  localparam int PG_W     = VA_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PTE_W-1:0]  req_pte,
  input  logic [PA_W-1:0]   req_pte_ptr,
  input  logic              req_store,
  input  logic              req_fetch,
  input  logic              req_super,
  input  logic              nf_mode,
  input  logic              traps_en,
  input  logic              reg_rd,
  input  logic              reg_sel,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic [CODE_W-1:0] rsp_code,
  output logic [2:0]        rsp_rights,
  output logic              wb_valid,
  output logic [PA_W-1:0]   wb_ptr,
  output logic [PTE_W-1:0]  wb_data,
  output logic              fault,
  output logic [VA_W-1:0]   reg_rdata
);
  logic [IDX_W-1:0]  ev_idx;
  logic [CODE_W-1:0] ev_code;
  rights_t           ev_rights;
  logic              ev_suppress;
  logic              ev_allow;
  logic              ev_record;
  logic              ev_trap;
  logic [PTE_W-1:0]  ev_pte_new;
  logic              ev_wb;
  logic [STAT_W-1:0] stat_q;

  assign ev_idx = make_index(req_store, req_fetch, req_super);

  mmu_perm_lookup u_lookup (
    .acc_idx   (ev_idx),
    .perm      (req_pte[PERM_LSB +: 3]),
    .mod_after (req_pte[MOD_BIT] | req_store),
    .code      (ev_code),
    .granted   (ev_rights)
  );

  assign ev_suppress = (ev_code != CODE_OK) && nf_mode && !req_super;
  assign ev_allow    = req_valid && ((ev_code == CODE_OK) || ev_suppress);
  assign ev_record   = req_valid && (ev_code != CODE_OK) && !ev_suppress;
  assign ev_trap     = ev_record && traps_en && !nf_mode;

  mmu_ref_update #(
    .PTE_W   (PTE_W),
    .REF_BIT (REF_BIT),
    .MOD_BIT (MOD_BIT)
  ) u_refupd (
    .pte      (req_pte),
    .is_store (req_store),
    .allow    (ev_allow),
    .pte_new  (ev_pte_new),
    .wb_need  (ev_wb)
  );

  mmu_fault_regs #(
    .VA_W      (VA_W),
    .PAGE_BITS (PAGE_BITS),
    .STAT_W    (STAT_W)
  ) u_fregs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_fault (ev_record),
    .rec_idx   (ev_idx),
    .rec_code  (ev_code),
    .rec_page  (req_vaddr[VA_W-1:PAGE_BITS]),
    .rd_en     (reg_rd),
    .rd_sel    (reg_sel),
    .rdata     (reg_rdata),
    .stat_q    (stat_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_allow  <= 1'b0;
      rsp_code   <= '0;
      rsp_rights <= '0;
      wb_valid   <= 1'b0;
      wb_ptr     <= '0;
      wb_data    <= '0;
      fault      <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      wb_valid  <= ev_wb;
      fault     <= ev_trap;
      if (req_valid) begin
        rsp_allow  <= ev_allow;
        rsp_code   <= ev_code;
        rsp_rights <= ev_allow ? ev_rights : 3'b000;
        wb_ptr     <= req_pte_ptr;
        wb_data    <= ev_pte_new;
      end
    end
  end
endmodule

// File: rtl/mmu_access_guard_chk.sv
module mmu_access_guard_chk #(
  parameter int PTE_W   = 32,
  parameter int REF_BIT = 5,
  parameter int MOD_BIT = 6,
  parameter int STAT_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTE_W-1:0] req_pte,
  input logic             req_store,
  input logic             nf_mode,
  input logic             traps_en,
  input logic             reg_rd,
  input logic             reg_sel,
  input logic             rsp_valid,
  input logic             rsp_allow,
  input logic [3:0]       rsp_code,
  input logic [2:0]       rsp_rights,
  input logic             wb_valid,
  input logic [PTE_W-1:0] wb_data,
  input logic             fault,
  input logic             ev_record,
  input logic [2:0]       ev_idx,
  input logic [STAT_W-1:0] stat_q
);
  // R2: only three result codes exist
  p_code_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code == 4'd0 || rsp_code == 4'd8 || rsp_code == 4'd12));

  // R4: write-back only for an allowed access, and it carries the referenced flag
  p_wb_allowed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (rsp_valid && rsp_allow && wb_data[REF_BIT]));

  // R5: write right needs the modified flag already set or set by this store
  p_write_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_rights[1]) |-> ($past(req_pte[MOD_BIT]) || $past(req_store)));

  // R6: a rejected access grants nothing
  p_reject_norights_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_allow) |-> (rsp_rights == 3'b000));

  // R7: a recorded fault leaves the valid marker and index in the status word
  p_stat_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_record |=> (stat_q[1] && stat_q[7:5] == $past(ev_idx)));

  // R9: a status read with no new fault clears the word
  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_sel && !ev_record) |=> (stat_q == '0));

  // R10: trap pulse is qualified and tied to a rejected response
  p_trap_qual_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (rsp_valid && !rsp_allow && $past(traps_en) && !$past(nf_mode)));
endmodule

bind mmu_access_guard mmu_access_guard_chk #(
  .PTE_W   (PTE_W),
  .REF_BIT (REF_BIT),
  .MOD_BIT (MOD_BIT),
  .STAT_W  (STAT_W)
) u_guard_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_pte    (req_pte),
  .req_store  (req_store),
  .nf_mode    (nf_mode),
  .traps_en   (traps_en),
  .reg_rd     (reg_rd),
  .reg_sel    (reg_sel),
  .rsp_valid  (rsp_valid),
  .rsp_allow  (rsp_allow),
  .rsp_code   (rsp_code),
  .rsp_rights (rsp_rights),
  .wb_valid   (wb_valid),
  .wb_data    (wb_data),
  .fault      (fault),
  .ev_record  (ev_record),
  .ev_idx     (ev_idx),
  .stat_q     (stat_q)
);

// File: tb/test_mmu_access_guard.sv
`timescale 1ns/1ps
module test_mmu_access_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_pte = '0;
  logic [35:0] req_pte_ptr = '0;
  logic        req_store = 1'b0, req_fetch = 1'b0, req_super = 1'b0;
  logic        nf_mode = 1'b0, traps_en = 1'b0;
  logic        reg_rd = 1'b0, reg_sel = 1'b0;
  logic        rsp_valid, rsp_allow, wb_valid, fault;
  logic [3:0]  rsp_code;
  logic [2:0]  rsp_rights;
  logic [35:0] wb_ptr;
  logic [31:0] wb_data, reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mmu_access_guard i_mmu_access_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_pte(req_pte), .req_pte_ptr(req_pte_ptr), .req_store(req_store),
    .req_fetch(req_fetch), .req_super(req_super), .nf_mode(nf_mode),
    .traps_en(traps_en), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_code(rsp_code),
    .rsp_rights(rsp_rights), .wb_valid(wb_valid), .wb_ptr(wb_ptr),
    .wb_data(wb_data), .fault(fault), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // rights {R,W,X} as 4/2/1
  function automatic int user_rt(int p);
    int t[8] = '{4, 6, 5, 7, 1, 4, 0, 0};
    return t[p];
  endfunction
  function automatic int sup_rt(int p);
    int t[8] = '{4, 6, 5, 7, 1, 6, 5, 7};
    return t[p];
  endfunction
  function automatic int model_code(int st, int fe, int sup, int p);
    int need;
    int have;
    have = sup ? sup_rt(p) : user_rt(p);
    need = (st ? 2 : 0) + (fe ? 1 : 0) + ((st == 0 && fe == 0) ? 4 : 0);
    if (!sup && p >= 6) return 12;
    if ((need & ~have) != 0) return 8;
    return 0;
  endfunction

  task automatic read_reg(input logic sel, output logic [31:0] val);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel;
    @(negedge clk);
    reg_rd = 1'b0;
    val = reg_rdata;
  endtask

  // one access; checks response, write-back, fault pulse; returns expected status
  task automatic access(input int st, fe, sup, p, rf, md, nf, tr,
                        input logic [31:0] va, input logic rd_with,
                        output int exp_stat_new, output logic recorded);
    int code, rt, idx, allow, newmod, wbn;
    logic [31:0] pte, pte_exp;
    code = model_code(st, fe, sup, p);
    idx = st * 4 + fe * 2 + sup;
    allow = (code == 0) || (nf != 0 && sup == 0);
    recorded = !allow;
    rt = sup ? sup_rt(p) : user_rt(p);
    newmod = md | st;
    if (!newmod) rt = rt & 5;
    if (!allow) rt = 0;
    pte = {25'h0A5C3 ^ 25'(va[31:12]), md[0], rf[0], p[2:0], 2'b10};
    pte_exp = pte | 32'h20 | (st ? 32'h40 : 32'h0);
    wbn = allow && (!rf || (st && !md));
    exp_stat_new = idx * 32 + code + 2;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_pte = pte;
    req_pte_ptr = {4'h9, va ^ 32'h0F0F_0000};
    req_store = st[0]; req_fetch = fe[0]; req_super = sup[0];
    nf_mode = nf[0]; traps_en = tr[0];
    reg_rd = rd_with; reg_sel = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; reg_rd = 1'b0;
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd1);
    chk("R2 rsp_code", 64'(rsp_code), 64'(code));
    chk("R3 rsp_allow", 64'(rsp_allow), 64'(allow));
    chk("R6 rsp_rights", 64'(rsp_rights), 64'(rt));
    chk("R4 wb_valid", 64'(wb_valid), 64'(wbn));
    if (wbn) begin
      chk("R4 wb_data", 64'(wb_data), 64'(pte_exp));
      chk("R4 wb_ptr", 64'(wb_ptr), 64'({4'h9, va ^ 32'h0F0F_0000}));
    end
    chk("R10 fault", 64'(fault), 64'(recorded && tr != 0 && nf == 0));
    @(negedge clk);
    chk("R10 fault one cycle", 64'(fault), 64'd0);
  endtask

  initial begin
    logic [31:0] v;
    int es, es2;
    logic rec, rec2;
    repeat (4) @(negedge clk);
    chk("R11 rsp_valid reset", 64'(rsp_valid), 64'd0);
    chk("R11 fault reset", 64'(fault), 64'd0);
    chk("R11 wb_valid reset", 64'(wb_valid), 64'd0);
    rst_n = 1'b1;
    read_reg(1'b0, v); chk("R11 status reset", 64'(v), 64'd0);
    read_reg(1'b1, v); chk("R11 address reset", 64'(v), 64'd0);

    // full sweep: index x perm x flags x modes
    for (int n = 0; n < 1024; n++) begin
      automatic int idx = n % 8;
      automatic int p   = (n / 8) % 8;
      automatic int rf  = (n / 64) % 2;
      automatic int md  = (n / 128) % 2;
      automatic int nf  = (n / 256) % 2;
      automatic int tr  = (n / 512) % 2;
      automatic logic [31:0] va = 32'h4000_0000 + 32'(n) * 32'h0000_3171;
      access(idx / 4, (idx / 2) % 2, idx % 2, p, rf, md, nf, tr, va, 1'b0, es, rec);
      read_reg(1'b0, v);
      chk("R7 status", 64'(v), rec ? 64'(es) : 64'd0);
      if (rec) begin
        read_reg(1'b1, v);
        chk("R8 fault address", 64'(v), 64'({va[31:12], 12'h000}));
      end
      read_reg(1'b0, v);
      chk("R9 status cleared by read", 64'(v), 64'd0);
    end

    // R7 overwrite: two faults, no read between
    access(0, 0, 0, 6, 1, 1, 0, 1, 32'h1234_5ABC, 1'b0, es, rec);
    access(1, 0, 1, 0, 1, 1, 0, 1, 32'h8765_4321, 1'b0, es2, rec2);
    read_reg(1'b0, v);
    chk("R7 overwrite marker", 64'(v), 64'(es2 | 1));
    read_reg(1'b1, v);
    chk("R8 second address kept", 64'(v), 64'h8765_4000);

    // R9 collision: fault in the same cycle as a status read
    access(0, 1, 0, 1, 1, 1, 0, 0, 32'hCAFE_1000, 1'b0, es, rec);
    access(0, 0, 0, 4, 1, 1, 0, 0, 32'hBEEF_2FFF, 1'b1, es2, rec2);
    chk("R9 read returns old status", 64'(reg_rdata), 64'(es));
    read_reg(1'b0, v);
    chk("R9 fresh status no overwrite", 64'(v), 64'(es2));

    // R3 supervisor fault in no-fault mode is still recorded, no trap
    access(0, 0, 1, 4, 1, 1, 1, 1, 32'h0000_7000, 1'b0, es, rec);
    read_reg(1'b0, v);
    chk("R3 supervisor fault recorded in nf mode", 64'(v), 64'(es));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule